// File: doc/BRIEF.md
# Trap Flag Register with Bit-Protected Read-Modify-Write

This block holds one sticky flag per trap source of a processor: an illegal-instruction condition, a stack underflow, a stack overflow and a non-maskable interrupt event. Hardware raises a flag with a one-cycle set pulse at any time. The CPU changes the flags with bit and bit-field instructions. These read the register in one phase and write it back in a later phase.

Stale read data must not wipe out an event that arrives between those two phases. For that reason, the write port carries a mask of the bits the instruction really targets, and only those bits take the written data. Every other bit keeps its live value, together with any hardware set that arrives in the same cycle. A set always beats a clear on the same bit.

The block presents the flag vector and a trap request. The request carries an indication that at least one class A (urgent) trap is pending, which lets a class A trap interrupt a class B service routine.

Top module: `trap_flag_reg`

## Requirements
- R1: After reset (active-low `rstN`), all flags are 0 and `trapReq` and `trapClassA` are 0.
- R2: A 1 on `hwSet[i]` at a clock edge makes `flags[i]` 1 from that edge on. The flag stays 1 until a write clears it. A flag never rises without a set pulse or a write of 1.
- R3: When `wrEn` is 1, each bit with `wrMask[i]`=1 takes `wrData[i]` at the clock edge, unless R5 applies.
- R4: When `wrEn` is 1, each bit with `wrMask[i]`=0 keeps its value, whatever `wrData[i]` is. A hardware set arriving on such a bit in the same cycle is kept.
- R5: When `hwSet[i]` and a masked write of 0 to bit i happen in the same cycle, the flag ends up 1.
- R6: `trapReq` is 1 exactly when at least one flag is 1. It follows the registered flags with no extra cycle.
- R7: `trapClassA` is 1 exactly when a class A flag is 1. With the default parameters, the class A flags are bit 1 (stack underflow), bit 2 (stack overflow) and bit 3 (non-maskable event). Bit 0 (illegal instruction) is class B, so bit 0 alone gives `trapReq`=1 and `trapClassA`=0.
- R8: When `wrEn` is 0, `wrData` and `wrMask` have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwSet | input | NUM_FLAGS | One-cycle hardware set pulses, one per flag |
| wrEn | input | 1 | Write phase of a bit instruction |
| wrData | input | NUM_FLAGS | Value written to the targeted bits |
| wrMask | input | NUM_FLAGS | Bits explicitly targeted by the instruction |
| flags | output | NUM_FLAGS | Current trap flags |
| trapReq | output | 1 | Any trap pending |
| trapClassA | output | 1 | A class A trap is pending |

## Verification
The hardest case to reach from the ports is an event that lands between the read and the write phase of a bit instruction. The bench models this directly. It takes a snapshot of the flags as the "read", then presents a write whose data holds the stale snapshot value on unmasked bits. In the same cycle, it pulses `hwSet` on one of those unmasked bits. It also pulses a set on the very bit being cleared, to cover the case where the set must win.

// File: rtl/trap_flag_pkg.sv
package trap_flag_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic applyWrite;   // write phase with a non-empty target mask
  } ctrlStrobes_t;
endpackage

// File: rtl/trap_flag_ctrl.sv
module trap_flag_ctrl #(
  parameter int NUM_FLAGS = 4,
  parameter logic [NUM_FLAGS-1:0] CLASS_A_MASK = 4'b1110
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [NUM_FLAGS-1:0] wrMask,
  input  logic [NUM_FLAGS-1:0] flags,
  output trap_flag_pkg::ctrlStrobes_t strobes,
  output logic                 trapReq,
  output logic                 trapClassA
);
  logic [NUM_FLAGS-1:0] classAPending;

  always_comb begin
    strobes.applyWrite = wrEn && (|wrMask);
    classAPending      = flags & CLASS_A_MASK;
    trapReq            = |flags;
    trapClassA         = |classAPending;
  end

  // R7: a class A indication is always part of a pending request
  assert_classa_in_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapClassA |-> trapReq);
endmodule

// File: rtl/trap_flag_dp.sv
module trap_flag_dp #(
  parameter int NUM_FLAGS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trap_flag_pkg::ctrlStrobes_t strobes,
  input  logic [NUM_FLAGS-1:0] hwSet,
  input  logic [NUM_FLAGS-1:0] wrData,
  input  logic [NUM_FLAGS-1:0] wrMask,
  output logic [NUM_FLAGS-1:0] flags
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
    logic targeted;
    logic swValue;
    logic flagQ;

    always_comb begin
      targeted = strobes.applyWrite && wrMask[i];
      swValue  = targeted ? wrData[i] : flagQ;
    end

    always_ff @(posedge clk) begin
      if (!rstN) flagQ <= 1'b0;
      else       flagQ <= hwSet[i] | swValue;   // set wins over clear
    end

    assign flags[i] = flagQ;

    // R5 / R2: a hardware set always lands
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
      hwSet[i] |=> flags[i]);
    // R4: an untargeted bit without a set keeps its value
    assert_hold_untargeted_R4: assert property (@(posedge clk) disable iff (!rstN)
      (!(strobes.applyWrite && wrMask[i]) && !hwSet[i]) |=> flags[i] == $past(flags[i]));
    // R3: a targeted bit takes the written data
    assert_masked_write_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.applyWrite && wrMask[i] && !hwSet[i]) |=> flags[i] == $past(wrData[i]));
    // R2: no flag rises without a cause
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
      (!hwSet[i] && !flags[i] && !(strobes.applyWrite && wrMask[i] && wrData[i])) |=> !flags[i]);
  end
endmodule

// File: rtl/trap_flag_reg.sv
module trap_flag_reg #(
  parameter int NUM_FLAGS = 4,
  parameter logic [NUM_FLAGS-1:0] CLASS_A_MASK = 4'b1110
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] hwSet,
  input  logic                 wrEn,
  input  logic [NUM_FLAGS-1:0] wrData,
  input  logic [NUM_FLAGS-1:0] wrMask,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 trapReq,
  output logic                 trapClassA
);
  trap_flag_pkg::ctrlStrobes_t strobes;

  trap_flag_ctrl #(.NUM_FLAGS(NUM_FLAGS), .CLASS_A_MASK(CLASS_A_MASK)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMask(wrMask), .flags(flags),
    .strobes(strobes), .trapReq(trapReq), .trapClassA(trapClassA));

  trap_flag_dp #(.NUM_FLAGS(NUM_FLAGS)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hwSet(hwSet),
    .wrData(wrData), .wrMask(wrMask), .flags(flags));
endmodule

// File: tb/trap_flag_reg_tb_top.sv
module trap_flag_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [N-1:0] CLASS_A = 4'b1110;

  typedef struct {
    logic [N-1:0] expFlags;
    string        tag;
  } expItem_t;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [N-1:0] hwSet = 0, wrData = 0, wrMask = 0;
  logic [N-1:0] flags;
  logic trapReq, trapClassA;

  int checks = 0, errors = 0;
  logic [N-1:0] model = 0;
  expItem_t scoreQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_flag_reg #(.NUM_FLAGS(N), .CLASS_A_MASK(CLASS_A)) dut_i (
    .clk(clk), .rstN(rstN), .hwSet(hwSet), .wrEn(wrEn), .wrData(wrData),
    .wrMask(wrMask), .flags(flags), .trapReq(trapReq), .trapClassA(trapClassA));

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, model update, expected item pushed
  task automatic step(input logic [N-1:0] hs, input logic en, input logic [N-1:0] d,
                      input logic [N-1:0] m, input string tag);
    expItem_t it;
    @(negedge clk);
    hwSet = hs; wrEn = en; wrData = d; wrMask = m;
    if (en) model = (m & d) | (~m & model);
    model = model | hs;
    it.expFlags = model; it.tag = tag;
    scoreQ.push_back(it);
  endtask

  // Monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (scoreQ.size() > 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        check({it.tag, " flags"}, flags, it.expFlags);
        check("R6 trapReq", {3'b0, trapReq}, {3'b0, |it.expFlags});
        check("R7 trapClassA", {3'b0, trapClassA}, {3'b0, |(it.expFlags & CLASS_A)});
      end
    end
  end

  logic [N-1:0] snap;
  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset flags", flags, '0);
    check("R1 reset req", {3'b0, trapReq}, 4'b0);
    check("R1 reset classA", {3'b0, trapClassA}, 4'b0);
    @(negedge clk); rstN = 1;
    step(4'b0000, 0, 4'b0000, 4'b0000, "R2 idle");
    step(4'b0001, 0, 4'b0000, 4'b0000, "R2 set class B bit0");
    step(4'b0000, 0, 4'b0000, 4'b0000, "R2 sticky");
    step(4'b0000, 0, 4'b1111, 4'b1111, "R8 wrEn low ignored");
    step(4'b0100, 0, 4'b0000, 4'b0000, "R7 set overflow");
    step(4'b0000, 1, 4'b0000, 4'b0100, "R3 clear bit2");
    step(4'b0000, 1, 4'b1010, 4'b1010, "R3 write ones");
    step(4'b0000, 1, 4'b0000, 4'b0000, "R4 empty mask");
    // read phase snapshot, then stale write with a set on an untargeted bit
    @(negedge clk); snap = flags;
    step(4'b0100, 1, snap & 4'b1011, 4'b1000, "R4 set kept during stale write");
    step(4'b0000, 1, 4'b1111, 4'b0001, "R4 untargeted unchanged by data");
    step(4'b0010, 1, 4'b0000, 4'b0010, "R5 set beats clear");
    step(4'b0000, 1, 4'b0000, 4'b1111, "R3 clear all");
    step(4'b0001, 1, 4'b0000, 4'b1110, "R7 class B only");
    step(4'b1000, 1, 4'b0000, 4'b0001, "R5 R7 mixed");
    step(4'b0000, 0, 4'b0000, 4'b0000, "R2 drain");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule